// File: doc/BRIEF.md
# 8-bit Binary ALU with Status Flags

This block is the purely combinational arithmetic unit of a small 8-bit accumulator machine. Each cycle the surrounding datapath presents an operation code, the accumulator, an operand byte and the current status flags. The block returns the new result byte and the updated negative, zero, overflow and carry flags. It has no clock and no storage. Writing the result and flags back into registers or memory is left to the caller.

The unit supports five operations:
- add with carry;
- subtract with borrow, where the borrow is the inverse of the carry flag;
- increment the operand;
- decrement the operand;
- load, which passes the operand through and refreshes only the sign and zero flags.

All arithmetic is binary. The decimal-mode flag is accepted as an input but has no effect on any output. Any flag that an operation does not define is copied from its input to its output unchanged.

Top module: `alu8_core`

## Requirements
- R1: With op_i = 1 (add), {c_o, res_o} equals acc_i + opnd_i + c_i as a 9-bit sum. res_o is the low 8 bits and c_o is bit 8.
- R2: With op_i = 2 (subtract), res_o equals (acc_i - opnd_i - (1 - c_i)) mod 256. c_o is 1 exactly when acc_i >= opnd_i + (1 - c_i), that is, when no borrow occurs.
- R3: For add and subtract, v_o is 1 exactly when the two's-complement value of the operation falls outside -128..127. For add, that value is acc + opnd + c_i. For subtract, it is acc - opnd - (1 - c_i).
- R4: For op_i values 0 to 4, n_o equals res_o bit 7, and z_o is 1 exactly when res_o is zero.
- R5: With op_i = 3 (increment), res_o is (opnd_i + 1) mod 256. With op_i = 4 (decrement), res_o is (opnd_i - 1) mod 256. In both cases c_o equals c_i and v_o equals v_i.
- R6: With op_i = 0 (load), res_o equals opnd_i, c_o equals c_i and v_o equals v_i.
- R7: dec_i has no effect on any output for any operation.
- R8: For op_i values 5 to 7, res_o equals acc_i, and n_o, z_o, v_o and c_o equal n_i, z_i, v_i and c_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation: 0 load, 1 add, 2 subtract, 3 increment, 4 decrement |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| v_i | input | 1 | Incoming overflow flag |
| c_i | input | 1 | Incoming carry flag (inverse borrow for subtract) |
| dec_i | input | 1 | Decimal-mode flag, ignored |
| res_o | output | 8 | Result byte |
| n_o | output | 1 | Negative flag out |
| z_o | output | 1 | Zero flag out |
| v_o | output | 1 | Overflow flag out |
| c_o | output | 1 | Carry flag out |

## Verification
The hardest cases to reach are the narrow boundaries of the add and subtract paths. One is signed overflow that appears only because the carry-in is counted, for example 0x7F + 0x00 with carry set. Another is a subtraction whose only borrow comes from a clear carry, for example 0x00 - 0x00 with carry clear. Random bytes seldom land on these exact pairs. The stimulus therefore sweeps every accumulator and operand pair for add and subtract with each carry-in value, which covers every such boundary. Seeded random vectors then toggle the pass-through flags, the decimal flag and the unused operation codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LD  = 3'd0,
    OP_ADC = 3'd1,
    OP_SBC = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // subtract = a + ~b + cin; carry set means no borrow
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] val_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assign val_o = down_i ? (val_i - ONE) : (val_i + ONE);
endmodule

// File: rtl/alu8_nz.sv
module alu8_nz #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             neg_o,
  output logic             zero_o
);
  assign neg_o  = val_i[WIDTH-1];
  assign zero_o = ~|val_i;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             n_i,
  input  logic             z_i,
  input  logic             v_i,
  input  logic             c_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] res_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o
);
  logic [WIDTH-1:0] as_sum, step_val;
  logic             as_cout, as_ovf;
  logic             res_n, res_z;
  logic             dec_unused;

  // binary only: decimal flag is deliberately ignored
  assign dec_unused = dec_i;

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .cin_i  (c_i),
    .sub_i  (op_i == OP_SBC),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  alu8_step #(.WIDTH(WIDTH)) u_step (
    .val_i  (opnd_i),
    .down_i (op_i == OP_DEC),
    .val_o  (step_val)
  );

  always_comb begin
    res_o = acc_i;
    c_o   = c_i;
    v_o   = v_i;
    case (op_i)
      OP_LD:          res_o = opnd_i;
      OP_ADC, OP_SBC: begin
        res_o = as_sum;
        c_o   = as_cout;
        v_o   = as_ovf;
      end
      OP_INC, OP_DEC: res_o = step_val;
      default:        res_o = acc_i;
    endcase
  end

  alu8_nz #(.WIDTH(WIDTH)) u_nz (
    .val_i  (res_o),
    .neg_o  (res_n),
    .zero_o (res_z)
  );

  always_comb begin
    if (op_i <= OP_DEC) begin
      n_o = res_n;
      z_o = res_z;
    end else begin
      n_o = n_i;
      z_o = z_i;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] opnd_i,
  input logic             n_i,
  input logic             z_i,
  input logic             v_i,
  input logic             c_i,
  input logic             dec_i,
  input logic [WIDTH-1:0] res_o,
  input logic             n_o,
  input logic             z_o,
  input logic             v_o,
  input logic             c_o
);
  logic dec_unused;
  assign dec_unused = dec_i;

  always_comb begin
    if (!$isunknown({op_i, acc_i, opnd_i, n_i, z_i, v_i, c_i})) begin
      if (op_i == OP_ADC)
        a_r1_add_sum: assert ({c_o, res_o} == ({1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, c_i}));
      if (op_i == OP_SBC)
        a_r2_sub_borrow: assert (c_o == ({1'b0, acc_i} >= ({1'b0, opnd_i} + {{WIDTH{1'b0}}, ~c_i})));
      if (op_i == OP_ADC && acc_i[WIDTH-1] != opnd_i[WIDTH-1])
        a_r3_no_overflow: assert (!v_o);
      if (op_i <= OP_DEC)
        a_r4_sign_zero: assert (n_o == res_o[WIDTH-1] && z_o == (res_o == '0));
      if (op_i == OP_INC || op_i == OP_DEC)
        a_r5_step_keeps_cv: assert (c_o == c_i && v_o == v_i);
      if (op_i == OP_LD)
        a_r6_load_pass: assert (res_o == opnd_i && c_o == c_i && v_o == v_i);
      if (op_i > OP_DEC)
        a_r8_idle_hold: assert (res_o == acc_i && n_o == n_i && z_o == z_i && v_o == v_i && c_o == c_i);
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] op_i;
  logic [7:0] acc_i, opnd_i;
  logic       n_i, z_i, v_i, c_i, dec_i;
  logic [7:0] res_o;
  logic       n_o, z_o, v_o, c_o;

  int total = 0;
  int bad   = 0;
  int wd    = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  alu8_core uut (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .n_i(n_i), .z_i(z_i), .v_i(v_i), .c_i(c_i), .dec_i(dec_i),
    .res_o(res_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  // expected {res, n, z, v, c}
  function automatic logic [11:0] model(input int op, input int a, input int b,
                                        input int cin, input int nin, input int zin, input int vin);
    int r, sa, sb, s;
    logic n, z, v, c;
    n = nin[0]; z = zin[0]; v = vin[0]; c = cin[0];
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0: r = b;
      1: begin
        r = a + b + cin;
        c = (r > 255);
        s = sa + sb + cin;
        v = (s > 127) || (s < -128);
      end
      2: begin
        r = a - b - (1 - cin);
        c = (r >= 0);
        s = sa - sb - (1 - cin);
        v = (s > 127) || (s < -128);
      end
      3: r = b + 1;
      4: r = b - 1;
      default: r = a;
    endcase
    r = r & 255;
    if (op <= 4) begin
      n = (r >= 128);
      z = (r == 0);
    end
    return {r[7:0], n, z, v, c};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R6 R4";
      1: return "R1 R3 R4";
      2: return "R2 R3 R4";
      3, 4: return "R5 R4";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input int op, input int a, input int b, input int cin,
                     input int nin, input int zin, input int vin, input int dec, input string tag);
    logic [11:0] exp_v, got;
    op_i = op[2:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    c_i = cin[0]; n_i = nin[0]; z_i = zin[0]; v_i = vin[0]; dec_i = dec[0];
    #2;
    exp_v = model(op, a, b, cin, nin, zin, vin);
    got   = {res_o, n_o, z_o, v_o, c_o};
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h nzvc=%04b exp res=%02h nzvc=%04b",
               tag, op, a, b, cin, got[11:4], got[3:0], exp_v[11:4], exp_v[3:0]);
    end
  endtask

  initial begin
    op_i = '0; acc_i = '0; opnd_i = '0;
    n_i = 0; z_i = 0; v_i = 0; c_i = 0; dec_i = 0;
    void'($urandom(32'h5eed_a108));
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // directed corners
    run(1, 8'h7f, 8'h01, 0, 0, 0, 0, 0, "R3 signed add overflow");
    run(1, 8'h7f, 8'h00, 1, 0, 0, 0, 0, "R3 overflow from carry-in");
    run(1, 8'hff, 8'h00, 1, 0, 0, 0, 0, "R1 R4 carry wraps to zero");
    run(2, 8'h80, 8'h01, 1, 0, 0, 0, 0, "R2 R3 signed sub overflow");
    run(2, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R2 borrow from clear carry");
    run(2, 8'h05, 8'h05, 1, 0, 0, 0, 0, "R2 R4 equal gives zero");
    run(3, 0, 8'hff, 1, 0, 0, 1, 0, "R5 inc wraps, C V kept");
    run(4, 0, 8'h00, 0, 0, 0, 1, 0, "R5 dec wraps, C V kept");
    run(0, 8'h12, 8'h00, 1, 1, 0, 1, 0, "R6 load zero keeps C V");
    run(5, 8'h3c, 8'h00, 1, 1, 1, 1, 0, "R8 idle code 5");
    run(7, 8'h00, 8'hff, 0, 0, 1, 0, 1, "R8 idle code 7");

    // exhaustive add and subtract
    for (int op = 1; op <= 2; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int c = 0; c < 2; c++)
            run(op, a, b, c, 0, 0, 0, 0, tag_of(op));

    // exhaustive load, inc, dec with flags forced high
    for (int op = 0; op <= 4; op++) begin
      if (op == 1 || op == 2) continue;
      for (int b = 0; b < 256; b++)
        run(op, 8'h55, b, 1, 1, 1, 1, 0, tag_of(op));
    end

    // random: decimal flag set, flag inputs and all op codes
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(7, 0));
      run(op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(1, 0)), 1,
          {"R7 ", tag_of(op)});
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done) begin
      wd++;
      if (wd > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired: got running exp finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule